// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block takes eight request lines, a mask vector, an in-service vector and a rotation offset. From these it decides whether a new interrupt should be raised toward the processor, and which line wins. Urgency is counted from the rotation offset: the line at the offset is the most urgent, the next line up is second, and the count wraps around. The winner of the unmasked requests is compared with the most urgent line that is still in service. The interrupt is raised only when the winner is strictly more urgent.

Two mode flags and a strap change which in-service lines count in that comparison. With the special-mask flag set, an in-service line whose mask bit is also set is ignored. With nested mode set on a master instance, the in-service bit of the cascade line (line 2) is ignored, so a slave can interrupt again while it is being serviced. The resolver itself is combinational. A parameter selects an output register, which is on by default.

Top module: `rpr_resolver`

## Requirements
- R1: A request line whose mask bit is 1 never wins and never raises the output on its own.
- R2: Urgency rank k (0 = most urgent) belongs to line (k + offset) mod 8. The reported line is the unmasked request with the lowest rank.
- R3: When no unmasked request exists, the valid output is 0 and the line output is 0.
- R4: The valid output is 1 only when the winner's rank is strictly lower than the rank of the most urgent counted in-service line. At equal or higher rank, valid is 0 and line is 0.
- R5: With special-mask set, in-service bits whose mask bit is 1 are left out of the in-service rank. With special-mask clear, those bits count.
- R6: With nested mode set and the master strap at 1, in-service bit 2 is left out of the in-service rank. On a slave, or with nested mode clear, bit 2 counts.
- R7: When no in-service line counts and an unmasked request exists, valid is 1.
- R8: With the output register on, both outputs show the result for the inputs present at the previous rising clock edge. While reset (active low) is asserted, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| reqVec | input | 8 | Request lines |
| maskVec | input | 8 | Mask bits, 1 = masked |
| servVec | input | 8 | In-service bits |
| rotOffset | input | 3 | Line that holds the highest urgency |
| specialMask | input | 1 | Leave masked in-service bits out of the comparison |
| nestedMode | input | 1 | Nested mode flag |
| isMaster | input | 1 | Strap: 1 = master instance |
| intValid | output | 1 | Raise interrupt |
| intLine | output | 3 | Winning line, 0 when not valid |

## Verification
With the output register on, each result is due exactly one clock after its inputs. The bench changes the inputs on a falling edge, lets one rising edge capture them, and reads both outputs on the next falling edge. Every check therefore compares one input set with its own result. Directed cases cover rotation wrap, equal rank, special mask, nested mode on master and on slave, and fully masked requests. Random stimulus with a fixed seed steps through all eight settings of the mode flags and the strap.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef struct packed {
    logic excludeMasked;
    logic excludeCascade;
  } ctrlStrobes_t;
endpackage

// File: rtl/rpr_ctrl.sv
module rpr_ctrl
  import rpr_pkg::*;
(
  input  logic         specialMask,
  input  logic         nestedMode,
  input  logic         isMaster,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.excludeMasked  = specialMask;
    strobes.excludeCascade = nestedMode & isMaster;
  end
endmodule

// File: rtl/rpr_datapath.sv
module rpr_datapath
  import rpr_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int CASCADE_IDX = 2,
  localparam int W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] reqVec,
  input  logic [NUM_LINES-1:0] maskVec,
  input  logic [NUM_LINES-1:0] servVec,
  input  logic [W-1:0]         rotOffset,
  input  ctrlStrobes_t         strobes,
  output logic                 valid,
  output logic [W-1:0]         line
);
  // rank search: returns NUM_LINES when the vector is empty
  function automatic logic [W:0] findRank(input logic [NUM_LINES-1:0] v,
                                          input logic [W-1:0] off);
    logic [W:0]   r;
    logic [W-1:0] idx;
    r = (W+1)'(NUM_LINES);
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      idx = W'(k) + off;
      if (v[idx]) r = (W+1)'(k);
    end
    return r;
  endfunction

  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] servEff;
  logic [W:0]           pendRank;
  logic [W:0]           servRank;

  assign pending = reqVec & ~maskVec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_serv
    if (i == CASCADE_IDX) begin : g_casc
      assign servEff[i] = servVec[i] & ~(strobes.excludeMasked & maskVec[i])
                          & ~strobes.excludeCascade;
    end else begin : g_norm
      assign servEff[i] = servVec[i] & ~(strobes.excludeMasked & maskVec[i]);
    end
  end

  always_comb begin
    pendRank = findRank(pending, rotOffset);
    servRank = findRank(servEff, rotOffset);
    valid    = (pendRank < servRank);
    line     = valid ? (pendRank[W-1:0] + rotOffset) : '0;
  end
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver
  import rpr_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int CASCADE_IDX = 2,
  parameter bit REG_OUT     = 1'b1,
  localparam int W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] reqVec,
  input  logic [NUM_LINES-1:0] maskVec,
  input  logic [NUM_LINES-1:0] servVec,
  input  logic [W-1:0]         rotOffset,
  input  logic                 specialMask,
  input  logic                 nestedMode,
  input  logic                 isMaster,
  output logic                 intValid,
  output logic [W-1:0]         intLine
);
  ctrlStrobes_t strobes;
  logic         combValid;
  logic [W-1:0] combLine;

  rpr_ctrl u_ctrl (
    .specialMask(specialMask), .nestedMode(nestedMode),
    .isMaster(isMaster), .strobes(strobes)
  );

  rpr_datapath #(.NUM_LINES(NUM_LINES), .CASCADE_IDX(CASCADE_IDX)) u_dp (
    .reqVec(reqVec), .maskVec(maskVec), .servVec(servVec),
    .rotOffset(rotOffset), .strobes(strobes),
    .valid(combValid), .line(combLine)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        intValid <= 1'b0;
        intLine  <= '0;
      end else begin
        intValid <= combValid;
        intLine  <= combLine;
      end
    end
  end else begin : g_comb
    assign intValid = combValid;
    assign intLine  = combLine;
  end

  logic [NUM_LINES-1:0] pendChk;
  assign pendChk = reqVec & ~maskVec;

  // R1
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    combValid |-> pendChk[combLine]);
  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !combValid |-> (combLine == '0));
  // R3
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendChk == '0) |-> !combValid);
  // R4
  not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (combValid && !specialMask && !(nestedMode && isMaster)) |-> !servVec[combLine]);
  // R7
  free_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((servVec == '0) && (pendChk != '0)) |-> combValid);
  // R8
  reg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT && $past(rst_n)) |=> (intValid == $past(combValid)));
endmodule

// File: tb/rpr_resolver_bench.sv
module rpr_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reqVec = '0, maskVec = '0, servVec = '0;
  logic [2:0] rotOffset = '0;
  logic       specialMask = 1'b0, nestedMode = 1'b0, isMaster = 1'b0;
  logic       intValid;
  logic [2:0] intLine;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rpr_resolver #(.NUM_LINES(8), .CASCADE_IDX(2), .REG_OUT(1'b1)) u_rpr_resolver (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .maskVec(maskVec),
    .servVec(servVec), .rotOffset(rotOffset), .specialMask(specialMask),
    .nestedMode(nestedMode), .isMaster(isMaster),
    .intValid(intValid), .intLine(intLine)
  );

  function automatic int rankOf(input logic [7:0] v, input logic [2:0] off);
    for (int k = 0; k < 8; k++)
      if (v[(k + off) % 8]) return k;
    return 8;
  endfunction

  function automatic logic [3:0] model(input logic [7:0] rq, mk, sv,
                                       input logic [2:0] off,
                                       input logic sm, nm, ms);
    logic [7:0] eff;
    int pr, cr;
    eff = sv;
    if (sm) eff = eff & ~mk;
    if (nm && ms) eff[2] = 1'b0;
    pr = rankOf(rq & ~mk, off);
    cr = rankOf(eff, off);
    if (pr < cr) return {1'b1, 3'((pr + off) % 8)};
    return 4'b0;
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if ({intValid, intLine} !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               tag, intValid, intLine, exp[3], exp[2:0]);
    end
  endtask

  task automatic apply(input string tag, input logic [7:0] rq, mk, sv,
                       input logic [2:0] off, input logic sm, nm, ms);
    @(negedge clk);
    reqVec = rq; maskVec = mk; servVec = sv; rotOffset = off;
    specialMask = sm; nestedMode = nm; isMaster = ms;
    @(negedge clk);
    check(tag, model(rq, mk, sv, off, sm, nm, ms));
  endtask

  initial begin
    reqVec = 8'hFF;
    repeat (3) @(negedge clk);
    check("R8 reset", 4'b0);
    rst_n = 1'b1;
    // rotation: offset 5, requests on 1 and 6 -> 6 wins (R2)
    apply("R2 wrap", 8'b0100_0010, 8'h00, 8'h00, 3'd5, 0, 0, 0);
    apply("R2 wrap2", 8'b0000_0010, 8'h00, 8'h00, 3'd5, 0, 0, 0);
    apply("R1 masked", 8'b0001_0000, 8'b0001_0000, 8'h00, 3'd0, 0, 0, 0);
    apply("R3 empty", 8'h00, 8'h00, 8'h0F, 3'd3, 0, 0, 0);
    apply("R4 equal", 8'b0000_1000, 8'h00, 8'b0000_1000, 3'd0, 0, 0, 0);
    apply("R4 higher", 8'b0000_0001, 8'h00, 8'b0000_1000, 3'd0, 0, 0, 0);
    apply("R5 off", 8'b0001_0000, 8'b0000_0010, 8'b0000_0010, 3'd0, 0, 0, 0);
    apply("R5 on", 8'b0001_0000, 8'b0000_0010, 8'b0000_0010, 3'd0, 1, 0, 0);
    apply("R6 master", 8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 0, 1, 1);
    apply("R6 slave", 8'b0000_0100, 8'h00, 8'b0000_0100, 3'd0, 0, 1, 0);
    apply("R7 free", 8'b1000_0000, 8'h00, 8'h00, 3'd7, 0, 0, 0);
    for (int i = 0; i < 2000; i++) begin
      apply("R2 random", 8'($urandom), 8'($urandom), 8'($urandom & $urandom),
            3'($urandom), i[0], i[1], i[2]);
    end
    done = 1;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule